// File: doc/BRIEF.md
# Single-Channel Peripheral Burst DMA

This block is one DMA channel. It copies data between memory and a peripheral one beat at a time: it reads a word from the source address, then writes it to the destination address. Software sets it up through a small register bus. It gives the two start addresses, a burst length code, a count of bursts, a beat width, and whether each side's address is held fixed. A peripheral paces the copy through request lines. Each burst waits until the selected request line is high, or until a software start flag is set.

While the channel runs, the source and destination registers hold the live running addresses, so software can read how far the transfer has gone. Software can pause the channel at a beat boundary and resume it later, or abort it by clearing the enable bit. When the channel finishes, or when the memory bus reports an error, it clears its own enable bit and writes a stop code. The interrupt line stays high while that code is present and its enable bit is set. Software writes zero to the stop field to clear the interrupt.

Top module: `dma_chan_top`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low. The register map is: global control at 0x00, channel control A at 0x10, channel control B at 0x14, source address at 0x18 and destination address at 0x1C.
- R2: Bits 23:20 of control A give the burst type. 0xB means 4 beats, 0xD means 8 beats, 0xF means 16 beats, and any other code means 1 beat. Bits 15:0 hold the burst count minus one, so a transfer moves (count+1) × burst beats.
- R3: Bits 27:26 of control B give the beat width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. `mem_size` carries 0, 1 or 2 to match, and an address that is not fixed advances by the width after each beat.
- R4: Bit 25 of control B (fixed source) and bit 24 (fixed destination) each hold that side's address constant for the whole transfer.
- R5: Each beat is one read at the current source address, followed by one write of the same data to the current destination address. Each access is held until `mem_ack`.
- R6: A burst starts only when the global enable (0x00 bit 31) is set, pause is clear, and one of two triggers is present. The first trigger is the request line picked by control A bits 28:24, seen through a synchroniser; a select value at or above NREQ never triggers. The second trigger is the software start flag at bit 29, which stays set until the transfer ends.
- R7: While the channel is enabled, the source and destination registers read back the address of the next beat.
- R8: Control A bit 30 (pause) stops the channel before the next beat starts. No memory access is lost or repeated. Clearing the bit resumes the transfer.
- R9: If software clears control A bit 31 (channel enable) during a transfer, the transfer stops. No further memory access is issued, even after pause is released, and the stop field stays 0.
- R10: After the last beat the channel clears its enable bit and its start flag, and sets the stop field (control B bits 18:16) to 3'b101.
- R11: An error response (`mem_err` together with `mem_ack`) ends the transfer. The channel sets the stop field to 3'b001, clears its enable bit, and does not advance the address of the failed beat.
- R12: `irq` is high while the stop field is 3'b101 and bit 19 (completion interrupt enable) is set, or while the stop field is 3'b001 and bit 20 (error interrupt enable) is set. A control B write with zero in bits 18:16 clears the stop field.
- R13: While the channel is enabled, writes to the address registers, and to the width, fixed-side and mode fields of control B, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| per_req | input | NREQ | Peripheral request lines |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_size | output | 2 | Beat size code (0, 1, 2) |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle access completion |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume two things about the memory side. First, `mem_ack` is a single-cycle pulse that arrives only while `mem_req` is high. Second, an error is flagged only together with an acknowledge. The memory model in the bench keeps to both: it acknowledges a pending access after zero to two wait cycles, drops the acknowledge on the next cycle, and raises `mem_err` only on one chosen access index. The assertions also assume that software does not change the address and width registers in the middle of a transfer. The design ignores such writes, and the bench issues them on purpose only while the transfer is paused, to show that they are ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [7:0] OFS_GLOBAL = 8'h00;
  localparam logic [7:0] OFS_CTLA   = 8'h10;
  localparam logic [7:0] OFS_CTLB   = 8'h14;
  localparam logic [7:0] OFS_SRC    = 8'h18;
  localparam logic [7:0] OFS_DST    = 8'h1C;

  localparam logic [2:0] STOP_NONE = 3'b000;
  localparam logic [2:0] STOP_DONE = 3'b101;
  localparam logic [2:0] STOP_ERR  = 3'b001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_GAP
  } eng_state_e;

  function automatic logic [4:0] beats_of(input logic [3:0] code);
    case (code)
      4'hB:    return 5'd4;
      4'hD:    return 5'd8;
      4'hF:    return 5'd16;
      default: return 5'd1;
    endcase
  endfunction

  function automatic logic [1:0] size_of(input logic [1:0] wcode);
    return (wcode == 2'd3) ? 2'd2 : wcode;
  endfunction
endpackage

// File: rtl/dma_trig.sv
module dma_trig #(
  parameter int NREQ        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] per_req,
  input  logic [4:0]      rsel,
  output logic            trig
);
  localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [NREQ-1:0] synced;

  for (genvar i = 0; i < NREQ; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SYNC_STAGES-2:0], per_req[i]};
    end
    assign synced[i] = sh[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst)                     trig <= 1'b0;
    else if (32'(rsel) < NREQ)   trig <= synced[rsel[IDX_W-1:0]];
    else                         trig <= 1'b0;
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs import dma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              glb_en,
  output logic              ch_en,
  output logic              pause,
  output logic              sw_go,
  output logic [4:0]        rsel,
  output logic [3:0]        btype,
  output logic [CNT_W-1:0]  tcount,
  output logic [1:0]        wcode,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              irq,
  input  logic              beat_done,
  input  logic              xfer_done,
  input  logic              xfer_err
);
  logic              glb_en_q, ch_en_q, pause_q, sw_go_q;
  logic [4:0]        rsel_q;
  logic [3:0]        btype_q, bcnt_q;
  logic [CNT_W-1:0]  tcount_q;
  logic [1:0]        mode_q, wcode_q;
  logic              fix_src_q, fix_dst_q, err_ie_q, done_ie_q;
  logic [2:0]        stop_q;
  logic [ADDR_W-1:0] src_q, dst_q, step;
  logic              irq_q;
  logic [31:0]       rdata_q, rd_mux;
  logic              wr_en;

  assign wr_en = bus_sel && bus_wr;
  always_comb step = ADDR_W'(32'd1 << size_of(wcode_q));

  always_comb begin
    case (bus_addr)
      OFS_GLOBAL: rd_mux = {glb_en_q, 31'd0};
      OFS_CTLA:   rd_mux = {ch_en_q, pause_q, sw_go_q, rsel_q, btype_q, bcnt_q, 16'(tcount_q)};
      OFS_CTLB:   rd_mux = {2'b00, mode_q, wcode_q, fix_src_q, fix_dst_q, 3'b000,
                            err_ie_q, done_ie_q, stop_q, 16'd0};
      OFS_SRC:    rd_mux = 32'(src_q);
      OFS_DST:    rd_mux = 32'(dst_q);
      default:    rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en_q <= 1'b0; ch_en_q <= 1'b0; pause_q <= 1'b0; sw_go_q <= 1'b0;
      rsel_q <= '0; btype_q <= '0; bcnt_q <= '0; tcount_q <= '0;
      mode_q <= '0; wcode_q <= '0; fix_src_q <= 1'b0; fix_dst_q <= 1'b0;
      err_ie_q <= 1'b0; done_ie_q <= 1'b0; stop_q <= STOP_NONE;
      src_q <= '0; dst_q <= '0; irq_q <= 1'b0; rdata_q <= '0;
    end else begin
      if (wr_en && bus_addr == OFS_GLOBAL) glb_en_q <= bus_wdata[31];
      if (wr_en && bus_addr == OFS_CTLA) begin
        ch_en_q <= bus_wdata[31];
        pause_q <= bus_wdata[30];
        sw_go_q <= bus_wdata[29];
        if (!ch_en_q) begin
          rsel_q   <= bus_wdata[28:24];
          btype_q  <= bus_wdata[23:20];
          bcnt_q   <= bus_wdata[19:16];
          tcount_q <= bus_wdata[CNT_W-1:0];
        end
      end
      if (wr_en && bus_addr == OFS_CTLB) begin
        if (!ch_en_q) begin
          mode_q    <= bus_wdata[29:28];
          wcode_q   <= bus_wdata[27:26];
          fix_src_q <= bus_wdata[25];
          fix_dst_q <= bus_wdata[24];
        end
        err_ie_q  <= bus_wdata[20];
        done_ie_q <= bus_wdata[19];
        if (bus_wdata[18:16] == 3'd0) stop_q <= STOP_NONE;
      end
      if (wr_en && bus_addr == OFS_SRC && !ch_en_q) src_q <= bus_wdata[ADDR_W-1:0];
      if (wr_en && bus_addr == OFS_DST && !ch_en_q) dst_q <= bus_wdata[ADDR_W-1:0];
      // hardware events take priority over software writes in the same cycle
      if (beat_done) begin
        if (!fix_src_q) src_q <= src_q + step;
        if (!fix_dst_q) dst_q <= dst_q + step;
      end
      if (xfer_done) begin
        ch_en_q <= 1'b0; sw_go_q <= 1'b0; stop_q <= STOP_DONE;
      end
      if (xfer_err) begin
        ch_en_q <= 1'b0; sw_go_q <= 1'b0; stop_q <= STOP_ERR;
      end
      irq_q <= (stop_q == STOP_DONE && done_ie_q) || (stop_q == STOP_ERR && err_ie_q);
      if (bus_sel && !bus_wr) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign glb_en    = glb_en_q;
  assign ch_en     = ch_en_q;
  assign pause     = pause_q;
  assign sw_go     = sw_go_q;
  assign rsel      = rsel_q;
  assign btype     = btype_q;
  assign tcount    = tcount_q;
  assign wcode     = wcode_q;
  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign irq       = irq_q;

  // R10: completion leaves the channel disabled with the done code
  a_r10_done_clears_en: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> (!ch_en_q && stop_q == STOP_DONE));
  // R11: an error leaves the channel disabled with the error code
  a_r11_err_clears_en: assert property (@(posedge clk) disable iff (rst)
    xfer_err |=> (!ch_en_q && stop_q == STOP_ERR));
  // R4: fixed sides never move
  a_r4_fixed_src: assert property (@(posedge clk) disable iff (rst)
    (beat_done && fix_src_q) |=> $stable(src_q));
  a_r4_fixed_dst: assert property (@(posedge clk) disable iff (rst)
    (beat_done && fix_dst_q) |=> $stable(dst_q));
  // R12: no interrupt without a stop code
  a_r12_irq_needs_stop: assert property (@(posedge clk) disable iff (rst)
    (stop_q == STOP_NONE) |=> !irq_q);
endmodule

// File: rtl/dma_engine.sv
module dma_engine import dma_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic              ch_en,
  input  logic              pause,
  input  logic              sw_go,
  input  logic              trig,
  input  logic [3:0]        btype,
  input  logic [CNT_W-1:0]  tcount,
  input  logic [1:0]        wcode,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              beat_done,
  output logic              xfer_done,
  output logic              xfer_err
);
  eng_state_e        st;
  logic [CNT_W-1:0]  burst_left;
  logic [4:0]        beat_left;
  logic [DATA_W-1:0] data_q;
  logic              go_ok;

  assign go_ok = glb_en && !pause;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; burst_left <= '0; beat_left <= '0; data_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ch_en) begin
          burst_left <= tcount;
          st         <= ST_WAIT;
        end
        ST_WAIT:
          if (!ch_en) st <= ST_IDLE;
          else if (go_ok && (trig || sw_go)) begin
            beat_left <= beats_of(btype) - 5'd1;
            st        <= ST_RD;
          end
        ST_RD:
          if (!ch_en) st <= ST_IDLE;
          else if (mem_ack) begin
            if (mem_err) st <= ST_IDLE;
            else begin
              data_q <= mem_rdata;
              st     <= ST_WR;
            end
          end
        ST_WR:
          if (!ch_en) st <= ST_IDLE;
          else if (mem_ack) begin
            if (mem_err) st <= ST_IDLE;
            else if (beat_left == '0) begin
              if (burst_left == '0) st <= ST_IDLE;
              else begin
                burst_left <= burst_left - 1'b1;
                st         <= ST_WAIT;
              end
            end else begin
              beat_left <= beat_left - 5'd1;
              st        <= ST_GAP;
            end
          end
        ST_GAP:
          if (!ch_en) st <= ST_IDLE;
          else if (go_ok) st <= ST_RD;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = (st == ST_WR) ? dst_addr : src_addr;
  assign mem_size  = size_of(wcode);
  assign mem_wdata = data_q;

  assign beat_done = ch_en && (st == ST_WR) && mem_ack && !mem_err;
  assign xfer_done = beat_done && (beat_left == '0) && (burst_left == '0);
  assign xfer_err  = ch_en && mem_req && mem_ack && mem_err;

  // R9: a cleared enable stops all memory traffic
  a_r9_abort_drops_req: assert property (@(posedge clk) disable iff (rst)
    !ch_en |=> !mem_req);
  // R5: an access holds its address and direction until acknowledged
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (!mem_req || ($stable(mem_addr) && $stable(mem_we))));
  // R8: a paused channel issues no new beat
  a_r8_pause_holds: assert property (@(posedge clk) disable iff (rst)
    (pause && (st == ST_GAP || st == ST_WAIT)) |=> !mem_req);
  // R6: a burst waits for a trigger
  a_r6_needs_trigger: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !trig && !sw_go) |=> (st != ST_RD));
  // R11: completion and error are exclusive
  a_r11_done_err_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xfer_done, xfer_err}));
endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top import dma_pkg::*; #(
  parameter int NREQ        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NREQ-1:0]   per_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              irq
);
  logic              glb_en, ch_en, pause, sw_go, trig;
  logic [4:0]        rsel;
  logic [3:0]        btype;
  logic [CNT_W-1:0]  tcount;
  logic [1:0]        wcode;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic              beat_done, xfer_done, xfer_err;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glb_en(glb_en), .ch_en(ch_en),
    .pause(pause), .sw_go(sw_go), .rsel(rsel), .btype(btype), .tcount(tcount),
    .wcode(wcode), .src_addr(src_addr), .dst_addr(dst_addr), .irq(irq),
    .beat_done(beat_done), .xfer_done(xfer_done), .xfer_err(xfer_err));

  dma_trig #(.NREQ(NREQ), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst(rst), .per_req(per_req), .rsel(rsel), .trig(trig));

  dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .glb_en(glb_en), .ch_en(ch_en), .pause(pause),
    .sw_go(sw_go), .trig(trig), .btype(btype), .tcount(tcount), .wcode(wcode),
    .src_addr(src_addr), .dst_addr(dst_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .beat_done(beat_done), .xfer_done(xfer_done), .xfer_err(xfer_err));
endmodule

// File: tb/dma_chan_top_tb.sv
module dma_chan_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 8;
  localparam logic [7:0] A_GLB = 8'h00, A_CA = 8'h10, A_CB = 8'h14, A_SRC = 8'h18, A_DST = 8'h1C;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [NREQ-1:0] per_req = 0;
  logic mem_req, mem_we, mem_ack = 0, mem_err = 0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [1:0] mem_size;

  int vec_n = 0, bad_n = 0;
  int log_n = 0, acc_n = 0, err_at = -1, dly = 0;
  logic [31:0] log_addr [128];
  logic [31:0] log_data [128];
  logic        log_we   [128];
  logic [1:0]  log_size [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_top #(.NREQ(NREQ)) u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_req(per_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq));

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1234};
  endfunction

  function automatic int nbeats(input logic [3:0] bt);
    case (bt)
      4'hB: return 4;
      4'hD: return 8;
      4'hF: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic int wbytes(input logic [1:0] wc);
    return (wc == 2'd0) ? 1 : (wc == 2'd1) ? 2 : 4;
  endfunction

  // memory model: acknowledges after 0..2 wait cycles, one-cycle ack pulse
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0; mem_err = 0;
    end else if (mem_ack) begin
      mem_ack = 0; mem_err = 0;
    end else if (mem_req) begin
      if (dly > 0) dly--;
      else begin
        mem_ack = 1;
        mem_rdata = pat(mem_addr);
        mem_err = (acc_n == err_at);
        if (log_n < 128) begin
          log_addr[log_n] = mem_addr; log_we[log_n] = mem_we;
          log_data[log_n] = mem_wdata; log_size[log_n] = mem_size;
        end
        log_n++; acc_n++;
        dly = int'($urandom % 3);
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vec_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; bus_sel = 0;
  endtask

  function automatic logic [31:0] ca_word(input bit en, pse, sw, input logic [4:0] rs,
                                          input logic [3:0] bt, input logic [15:0] tc);
    return {en, pse, sw, rs, bt, 4'h0, tc};
  endfunction

  task automatic setup(input logic [31:0] src, dst, input logic [3:0] bt, input logic [15:0] tc,
                       input logic [1:0] wc, input bit fs, fd, sw, input logic [4:0] rs,
                       input bit eie, die);
    log_n = 0; acc_n = 0;
    bus_write(A_SRC, src);
    bus_write(A_DST, dst);
    bus_write(A_CB, {2'b00, 2'b10, wc, fs, fd, 3'b000, eie, die, 3'b000, 16'd0});
    bus_write(A_CA, ca_word(1'b1, 1'b0, sw, rs, bt, tc));
  endtask

  task automatic wait_idle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      bus_read(A_CA, v);
      if (!v[31]) begin ok = 1; break; end
    end
  endtask

  task automatic check_xfer(input logic [31:0] src, dst, input logic [3:0] bt, input int tc,
                            input logic [1:0] wc, input bit fs, fd, die, input string rq);
    int n, w, bad;
    logic [31:0] fa, fe, v, sa, da;
    bit ok;
    n = nbeats(bt) * (tc + 1); w = wbytes(wc); bad = 0; fa = 0; fe = 0;
    wait_idle(ok);
    chk(ok, {rq, " R10 channel returns idle"}, {31'd0, ok}, 32'd1);
    chk(log_n == 2 * n, {rq, " R2 access count"}, log_n, 2 * n);
    for (int k = 0; k < n && 2 * k + 1 < 128; k++) begin
      sa = src + (fs ? 0 : k * w);
      da = dst + (fd ? 0 : k * w);
      if (bad == 0 && (log_addr[2*k] != sa || log_we[2*k])) begin bad++; fa = log_addr[2*k]; fe = sa; end
      if (bad == 0 && (log_addr[2*k+1] != da || !log_we[2*k+1])) begin bad++; fa = log_addr[2*k+1]; fe = da; end
      if (bad == 0 && log_data[2*k+1] != pat(sa)) begin bad++; fa = log_data[2*k+1]; fe = pat(sa); end
      if (bad == 0 && log_size[2*k] != ((wc == 2'd3) ? 2'd2 : wc)) begin bad++; fa = 32'(log_size[2*k]); fe = 32'(wc); end
    end
    chk(bad == 0, {rq, " R3 R4 R5 beat sequence"}, fa, fe);
    bus_read(A_SRC, v);
    chk(v == src + (fs ? 0 : n * w), {rq, " R7 R4 final source"}, v, src + (fs ? 0 : n * w));
    bus_read(A_DST, v);
    chk(v == dst + (fd ? 0 : n * w), {rq, " R7 R4 final destination"}, v, dst + (fd ? 0 : n * w));
    bus_read(A_CB, v);
    chk(v[18:16] == 3'b101, {rq, " R10 stop code"}, 32'(v[18:16]), 32'h5);
    bus_read(A_CA, v);
    chk(v[31:29] == 3'b000, {rq, " R10 enable and start cleared"}, 32'(v[31:29]), 0);
    chk(irq == die, {rq, " R12 irq vs enable"}, 32'(irq), 32'(die));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec_n++; bad_n++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  initial begin
    logic [31:0] v, src, dst;
    logic [3:0] bt;
    logic [1:0] wc;
    int tc, n1;
    bit fs, fd, sw, ok;
    logic [4:0] rs;
    void'($urandom(32'h1357));

    repeat (4) @(negedge clk);
    rst = 0;

    // R1: reset state
    bus_read(A_GLB, v); chk(v == 0, "R1 global reset", v, 0);
    bus_read(A_CA, v);  chk(v == 0, "R1 control A reset", v, 0);
    bus_read(A_CB, v);  chk(v == 0, "R1 control B reset", v, 0);
    bus_read(A_SRC, v); chk(v == 0, "R1 source reset", v, 0);
    bus_read(A_DST, v); chk(v == 0, "R1 destination reset", v, 0);
    chk(!irq && !mem_req, "R1 irq and mem_req low", {30'd0, irq, mem_req}, 0);

    // R6: global enable gates software-started transfer
    setup(32'h1000_0000, 32'h2000_0000, 4'hB, 16'd1, 2'd2, 0, 0, 1, 5'd0, 1, 1);
    repeat (40) @(negedge clk);
    chk(log_n == 0, "R6 no traffic while global enable low", log_n, 0);
    bus_write(A_GLB, 32'h8000_0000);
    check_xfer(32'h1000_0000, 32'h2000_0000, 4'hB, 1, 2'd2, 0, 0, 1, "R6 sw start");
    bus_write(A_CB, 32'h0018_0000);
    repeat (3) @(negedge clk);
    chk(!irq, "R12 ack by writing zero stop", 32'(irq), 0);
    bus_read(A_CB, v);
    chk(v[18:16] == 0, "R12 stop cleared", 32'(v[18:16]), 0);

    // R6: select out of range never triggers
    per_req = '1;
    setup(32'h1000_0100, 32'h2000_0100, 4'h0, 16'd3, 2'd0, 0, 0, 0, 5'd20, 1, 1);
    repeat (40) @(negedge clk);
    chk(log_n == 0, "R6 out-of-range select ignored", log_n, 0);
    bus_write(A_CA, ca_word(0, 0, 0, 5'd20, 4'h0, 16'd3));
    per_req = '0;

    // R6: in-range select waits for its request line
    setup(32'h1000_0200, 32'h2000_0300, 4'hF, 16'd1, 2'd2, 0, 0, 0, 5'd3, 1, 1);
    per_req = 8'b1111_0111;
    repeat (40) @(negedge clk);
    chk(log_n == 0, "R6 other request lines ignored", log_n, 0);
    per_req = 8'b0000_1000;
    check_xfer(32'h1000_0200, 32'h2000_0300, 4'hF, 1, 2'd2, 0, 0, 1, "R6 request trigger R2");
    per_req = '0;

    // random transfers
    for (int it = 0; it < 12; it++) begin
      case ($urandom % 4)
        0: begin bt = 4'hF; tc = int'($urandom % 2); end
        1: begin bt = 4'hD; tc = int'($urandom % 4); end
        2: begin bt = 4'hB; tc = int'($urandom % 8); end
        default: begin bt = 4'h3; tc = int'($urandom % 32); end
      endcase
      wc = 2'($urandom % 4);
      fs = 1'($urandom % 2); fd = 1'($urandom % 2); sw = 1'($urandom % 2);
      rs = 5'($urandom % NREQ);
      src = 32'h1000_0000 | ($urandom & 32'h0000_FFF0);
      dst = 32'h3000_0000 | ($urandom & 32'h0000_FFF0);
      setup(src, dst, bt, 16'(tc), wc, fs, fd, sw, rs, 1, 1);
      if (!sw) per_req = NREQ'(1) << rs;
      check_xfer(src, dst, bt, tc, wc, fs, fd, 1, "R2 R3 R4 random");
      per_req = '0;
      bus_write(A_CB, 32'h0018_0000);
    end

    // R8, R7, R13: pause mid-transfer, inspect, then resume
    setup(32'h1100_0000, 32'h2200_0000, 4'hD, 16'd3, 2'd1, 0, 0, 1, 5'd0, 1, 1);
    while (log_n < 10) @(negedge clk);
    bus_write(A_CA, ca_word(1, 1, 1, 5'd0, 4'hD, 16'd3));
    repeat (30) @(negedge clk);
    n1 = log_n;
    repeat (60) @(negedge clk);
    chk(log_n == n1, "R8 no traffic while paused", log_n, n1);
    chk(n1 % 2 == 0, "R8 pause at beat boundary", n1, n1 & ~1);
    bus_read(A_DST, v);
    chk(v == 32'h2200_0000 + n1, "R7 live destination", v, 32'h2200_0000 + n1);
    bus_write(A_SRC, 32'hDEAD_0000);
    bus_read(A_SRC, v);
    chk(v == 32'h1100_0000 + n1, "R13 source write ignored while enabled", v, 32'h1100_0000 + n1);
    bus_write(A_CB, {2'b00, 2'b10, 2'd0, 1'b1, 1'b1, 3'b000, 1'b1, 1'b1, 3'b000, 16'd0});
    bus_read(A_CB, v);
    chk(v[27:24] == 4'b0100, "R13 width and fixed bits locked", 32'(v[27:24]), 32'h4);
    bus_write(A_CA, ca_word(1, 0, 1, 5'd0, 4'hD, 16'd3));
    check_xfer(32'h1100_0000, 32'h2200_0000, 4'hD, 3, 2'd1, 0, 0, 1, "R8 resume");
    bus_write(A_CB, 32'h0018_0000);

    // R9: abort while paused, then release pause
    setup(32'h1200_0000, 32'h2300_0000, 4'hF, 16'd1, 2'd2, 0, 0, 1, 5'd0, 1, 1);
    while (log_n < 6) @(negedge clk);
    bus_write(A_CA, ca_word(1, 1, 1, 5'd0, 4'hF, 16'd1));
    repeat (20) @(negedge clk);
    bus_write(A_CA, ca_word(0, 1, 0, 5'd0, 4'hF, 16'd1));
    repeat (10) @(negedge clk);
    n1 = log_n;
    bus_write(A_CA, ca_word(0, 0, 0, 5'd0, 4'hF, 16'd1));
    repeat (60) @(negedge clk);
    chk(log_n == n1, "R9 no traffic after abort", log_n, n1);
    bus_read(A_CA, v);
    chk(!v[31], "R9 channel disabled", 32'(v[31]), 0);
    bus_read(A_CB, v);
    chk(v[18:16] == 0, "R9 no stop code", 32'(v[18:16]), 0);
    chk(!irq, "R9 no interrupt", 32'(irq), 0);

    // R11: error response on access index 5 (write of the third beat)
    err_at = 5;
    setup(32'h1300_0000, 32'h2400_0000, 4'hB, 16'd1, 2'd2, 0, 0, 1, 5'd0, 1, 0);
    wait_idle(ok);
    err_at = -1;
    chk(log_n == 6, "R11 stops at failing access", log_n, 6);
    bus_read(A_CB, v);
    chk(v[18:16] == 3'b001, "R11 error stop code", 32'(v[18:16]), 1);
    bus_read(A_DST, v);
    chk(v == 32'h2400_0008, "R11 failed beat not advanced", v, 32'h2400_0008);
    chk(irq, "R12 error interrupt", 32'(irq), 1);
    bus_write(A_CB, 32'h0010_0000);
    repeat (3) @(negedge clk);
    chk(!irq, "R12 error ack", 32'(irq), 0);

    // R12: completion interrupt masked
    setup(32'h1400_0000, 32'h2500_0000, 4'hB, 16'd0, 2'd2, 0, 1, 1, 5'd0, 1, 0);
    check_xfer(32'h1400_0000, 32'h2500_0000, 4'hB, 0, 2'd2, 0, 1, 0, "R12 masked");

    $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end
endmodule